// File: doc/BRIEF.md
# Memory Built-In Self-Test Sequencer

This block masters a word-addressed memory port and runs three self-tests one after another. The first is a bus test that writes alternating-bit words and then reads them back. The second is a data test that writes a pseudo-random word stream and then regenerates that stream to check the read-back. The third is an address test that scatters iteration numbers across generated addresses and reads them back. Each test is a write pass followed by a read-and-compare pass. Each test keeps its own mismatch count. When all three tests are over, the engine raises a done flag and a pass flag.

The memory port is a valid/ready request channel. One beat carries a write flag, a word address and write data. The engine holds a beat on the port until the memory accepts it. For a read, the memory presents the read word on `mem_rdata` in the same cycle that it accepts the read request. `mem_req_ready` may be low for any number of cycles, and the engine waits without limit. The test sizes, the base address and the generator modes are parameters.

Top module: `mbist_seq`

## Requirements
- R1: After reset, and until the first start, `mem_req_valid`, `done` and `pass_ok` are low and all three error counters are zero.
- R2: The bus test writes 0xAAAAAAAA to addresses BASE_ADDR+k for k = 0 to BUS_WORDS-1 in ascending order, then reads the same addresses in the same order. It then repeats both passes with 0x55555555. Every read that differs from the pattern in any bit adds one to `err_bus`.
- R3: The data test writes BUS-independent words x1, x2, ... to BASE_ADDR+k, k = 0 to DATA_WORDS-1, where x0 = 0 and x(n+1) = 1664525*x(n) + 1013904223 mod 2^32 (random mode, the default). The read pass restarts from x0 = 0 and compares whole words. Each mismatch adds one to `err_data`.
- R4: The address test runs ADDR_ITERS iterations. Iteration k writes the value k to BASE_ADDR+g(k+1), where g0 = 0. In incrementing mode (the default) g(n+1) = g(n)+1; in random mode g(n+1) = 25173*g(n) + 13849 mod 2^16. The read pass restarts from g0 = 0 and compares only bits 15:0 of the read word with k. Each mismatch adds one to `err_addr`.
- R5: A mismatching read increments only the counter of the test it belongs to. Write beats never change any counter.
- R6: `done` rises in the cycle after the last address-test read is accepted. It stays high until the next start, and `mem_req_valid` is low while it is high. `pass_ok` is high exactly when `done` is high and all three counters are zero.
- R7: While `mem_req_valid` is high and `mem_req_ready` is low, `mem_req_write`, `mem_req_addr` and `mem_req_wdata` hold their values and the sequence does not advance. `mem_rdata` is sampled only in the cycle that accepts a read.
- R8: A start pulse that arrives while a test sequence is running has no effect on the request stream or on the counters.
- R9: A start pulse while idle or done clears all counters and `done` by the next cycle, and begins a new bus-test write pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a full test sequence (single-cycle pulse) |
| mem_req_valid | output | 1 | Request beat present |
| mem_req_ready | input | 1 | Memory accepts the beat this cycle |
| mem_req_write | output | 1 | 1 = write beat, 0 = read beat |
| mem_req_addr | output | AW | Word address |
| mem_req_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read word, valid in the cycle a read is accepted |
| done | output | 1 | All three tests finished |
| pass_ok | output | 1 | Done with zero mismatches |
| err_bus | output | $clog2(2*BUS_WORDS+1) | Bus-test mismatch count |
| err_data | output | $clog2(DATA_WORDS+1) | Data-test mismatch count |
| err_addr | output | $clog2(ADDR_ITERS+1) | Address-test mismatch count |

## Verification
The assertions assume that `start` is a clean pulse. They also assume that the memory returns the read word in the same cycle that it raises `mem_req_ready` for a read, so every read result belongs to the beat that is on the port. The bench keeps to these assumptions. Its responder drives `mem_req_ready` from a pseudo-random sequence, or holds it high. It presents stored data, with bits flipped on chosen reads, only in the accepting cycle, and it drives `start` for exactly one cycle. Flipping only high-order bits during the address test checks that those bits are ignored. A start pulse issued mid-run checks that it is ignored.

// File: rtl/mbist_pkg.sv
package mbist_pkg;

  typedef enum logic [3:0] {
    PH_IDLE   = 4'd0,
    PH_BUS_WA = 4'd1,
    PH_BUS_RA = 4'd2,
    PH_BUS_WB = 4'd3,
    PH_BUS_RB = 4'd4,
    PH_DAT_W  = 4'd5,
    PH_DAT_R  = 4'd6,
    PH_ADR_W  = 4'd7,
    PH_ADR_R  = 4'd8,
    PH_DONE   = 4'd9
  } phase_e;

  localparam logic [31:0] PAT_ODD  = 32'hAAAA_AAAA;
  localparam logic [31:0] PAT_EVEN = 32'h5555_5555;

  function automatic logic ph_active(phase_e p);
    return (p != PH_IDLE) && (p != PH_DONE);
  endfunction

  function automatic logic ph_write(phase_e p);
    return (p == PH_BUS_WA) || (p == PH_BUS_WB) || (p == PH_DAT_W) || (p == PH_ADR_W);
  endfunction

  function automatic logic ph_read(phase_e p);
    return (p == PH_BUS_RA) || (p == PH_BUS_RB) || (p == PH_DAT_R) || (p == PH_ADR_R);
  endfunction

  function automatic logic ph_bus(phase_e p);
    return (p == PH_BUS_WA) || (p == PH_BUS_RA) || (p == PH_BUS_WB) || (p == PH_BUS_RB);
  endfunction

  function automatic logic ph_dat(phase_e p);
    return (p == PH_DAT_W) || (p == PH_DAT_R);
  endfunction

  function automatic logic ph_adr(phase_e p);
    return (p == PH_ADR_W) || (p == PH_ADR_R);
  endfunction

endpackage

// File: rtl/mbist_lcg.sv
module mbist_lcg #(
  parameter int          W      = 32,
  parameter bit          RANDOM = 1'b1,
  parameter int unsigned MUL    = 32'd1664525,
  parameter int unsigned INC    = 32'd1013904223
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         step,
  output logic [W-1:0] value
);

  localparam logic [W-1:0] MUL_W = W'(MUL);
  localparam logic [W-1:0] INC_W = W'(INC);

  logic [W-1:0] seed;
  logic [W-1:0] nxt;

  generate
    if (RANDOM) begin : g_lcg
      assign nxt = MUL_W * seed + INC_W;
    end else begin : g_incr
      assign nxt = seed + W'(1);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)    seed <= '0;
    else if (clr)  seed <= '0;
    else if (step) seed <= nxt;
  end

  assign value = nxt;

  // R7
  lcg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !step) |=> $stable(value));

endmodule

// File: rtl/mbist_errcnt.sv
module mbist_errcnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] count
);

  always_ff @(posedge clk) begin
    if (!rst_n)                      count <= '0;
    else if (clr)                    count <= '0;
    else if (inc && (count != '1))   count <= count + W'(1);
  end

  // R5
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr && (count != '1)) |=> (count == $past(count) + W'(1)));

  // R9
  cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0));

endmodule

// File: rtl/mbist_ctrl.sv
module mbist_ctrl
  import mbist_pkg::*;
#(
  parameter int BUS_WORDS  = 128,
  parameter int DATA_WORDS = 524288,
  parameter int ADDR_ITERS = 8192,
  parameter int IW         = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          hs,
  output phase_e        phase,
  output logic [IW-1:0] idx,
  output logic          last,
  output logic          launch
);

  logic          active;
  logic [IW-1:0] len_m1;

  assign active = ph_active(phase);
  assign launch = start && !active;

  always_comb begin
    if (ph_bus(phase))      len_m1 = IW'(BUS_WORDS - 1);
    else if (ph_dat(phase)) len_m1 = IW'(DATA_WORDS - 1);
    else if (ph_adr(phase)) len_m1 = IW'(ADDR_ITERS - 1);
    else                    len_m1 = '0;
  end

  assign last = (idx == len_m1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      idx   <= '0;
    end else if (launch) begin
      phase <= PH_BUS_WA;
      idx   <= '0;
    end else if (hs) begin
      if (last) begin
        phase <= phase_e'(phase + 4'd1);
        idx   <= '0;
      end else begin
        idx   <= idx + IW'(1);
      end
    end
  end

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !hs) |=> ($stable(phase) && $stable(idx)));

  // R8
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !(hs && last)) |=> (phase == $past(phase)));

  // R2
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (idx <= len_m1));

endmodule

// File: rtl/mbist_seq.sv
module mbist_seq
  import mbist_pkg::*;
#(
  parameter int            AW          = 32,
  parameter logic [AW-1:0] BASE_ADDR   = '0,
  parameter int            BUS_WORDS   = 128,
  parameter int            DATA_WORDS  = 524288,
  parameter int            ADDR_ITERS  = 8192,
  parameter bit            DATA_RANDOM = 1'b1,
  parameter bit            ADDR_RANDOM = 1'b0,
  localparam int           EBW = $clog2(2*BUS_WORDS + 1),
  localparam int           EDW = $clog2(DATA_WORDS + 1),
  localparam int           EAW = $clog2(ADDR_ITERS + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  output logic           mem_req_valid,
  input  logic           mem_req_ready,
  output logic           mem_req_write,
  output logic [AW-1:0]  mem_req_addr,
  output logic [31:0]    mem_req_wdata,
  input  logic [31:0]    mem_rdata,
  output logic           done,
  output logic           pass_ok,
  output logic [EBW-1:0] err_bus,
  output logic [EDW-1:0] err_data,
  output logic [EAW-1:0] err_addr
);

  localparam int MAX_AB = (BUS_WORDS > ADDR_ITERS) ? BUS_WORDS : ADDR_ITERS;
  localparam int MAXN   = (MAX_AB > DATA_WORDS) ? MAX_AB : DATA_WORDS;
  localparam int IW     = $clog2(MAXN + 1);

  phase_e        phase;
  logic [IW-1:0] idx;
  logic          last;
  logic          launch;
  logic          hs;
  logic [31:0]   gen32;
  logic [15:0]   gen16;
  logic [AW-1:0] offset;
  logic [31:0]   word;
  logic          mismatch;
  logic          rd_hs;

  assign hs    = mem_req_valid && mem_req_ready;
  assign rd_hs = hs && ph_read(phase);

  mbist_ctrl #(
    .BUS_WORDS  (BUS_WORDS),
    .DATA_WORDS (DATA_WORDS),
    .ADDR_ITERS (ADDR_ITERS),
    .IW         (IW)
  ) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .hs     (hs),
    .phase  (phase),
    .idx    (idx),
    .last   (last),
    .launch (launch)
  );

  mbist_lcg #(
    .W (32), .RANDOM (DATA_RANDOM), .MUL (32'd1664525), .INC (32'd1013904223)
  ) u_gen_data (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (launch || (hs && last)),
    .step  (hs && ph_dat(phase)),
    .value (gen32)
  );

  mbist_lcg #(
    .W (16), .RANDOM (ADDR_RANDOM), .MUL (32'd25173), .INC (32'd13849)
  ) u_gen_addr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (launch || (hs && last)),
    .step  (hs && ph_adr(phase)),
    .value (gen16)
  );

  always_comb begin
    offset = AW'(idx);
    word   = gen32;
    if (ph_bus(phase)) begin
      word = ((phase == PH_BUS_WA) || (phase == PH_BUS_RA)) ? PAT_ODD : PAT_EVEN;
    end else if (ph_adr(phase)) begin
      offset = AW'(gen16);
      word   = 32'(idx);
    end
  end

  assign mismatch = ph_adr(phase) ? (mem_rdata[15:0] != 16'(idx)) : (mem_rdata != word);

  assign mem_req_valid = ph_active(phase);
  assign mem_req_write = ph_write(phase);
  assign mem_req_addr  = BASE_ADDR + offset;
  assign mem_req_wdata = word;

  mbist_errcnt #(.W (EBW)) u_cnt_bus (
    .clk (clk), .rst_n (rst_n), .clr (launch),
    .inc (rd_hs && ph_bus(phase) && mismatch), .count (err_bus)
  );

  mbist_errcnt #(.W (EDW)) u_cnt_data (
    .clk (clk), .rst_n (rst_n), .clr (launch),
    .inc (rd_hs && ph_dat(phase) && mismatch), .count (err_data)
  );

  mbist_errcnt #(.W (EAW)) u_cnt_addr (
    .clk (clk), .rst_n (rst_n), .clr (launch),
    .inc (rd_hs && ph_adr(phase) && mismatch), .count (err_addr)
  );

  assign done    = (phase == PH_DONE);
  assign pass_ok = done && (err_bus == '0) && (err_data == '0) && (err_addr == '0);

  // R7
  req_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_write) && $stable(mem_req_addr) && $stable(mem_req_wdata)));

  // R6
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_req_valid);

  // R5
  bus_cnt_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(err_bus) |-> $past(launch || (rd_hs && ph_bus(phase))));

  // R5
  addr_cnt_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(err_addr) |-> $past(launch || (rd_hs && ph_adr(phase))));

endmodule

// File: tb/mbist_seq_bench.sv
`timescale 1ns/1ps
module mbist_seq_bench;

  localparam int           AW   = 20;
  localparam logic [19:0]  BASE = 20'h01000;
  localparam int           BW   = 8;
  localparam int           DW   = 40;
  localparam int           AI   = 24;
  localparam int           EBW  = $clog2(2*BW + 1);
  localparam int           EDW  = $clog2(DW + 1);
  localparam int           EAW  = $clog2(AI + 1);

  // columns: bus flips, data flips, addr flips, high-bits-only, stall, mid-run start
  localparam int NV = 6;
  localparam int VEC [NV][6] = '{
    '{0,  0,  0,  0, 0, 0},
    '{3,  0,  0,  0, 1, 0},
    '{0,  5,  0,  0, 0, 0},
    '{0,  0,  4,  0, 1, 0},
    '{0,  0,  6,  1, 0, 0},
    '{20, 50, 30, 0, 1, 1}
  };

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic           mem_req_valid;
  logic           mem_req_ready = 1'b0;
  logic           mem_req_write;
  logic [AW-1:0]  mem_req_addr;
  logic [31:0]    mem_req_wdata;
  logic [31:0]    mem_rdata = '0;
  logic           done;
  logic           pass_ok;
  logic [EBW-1:0] err_bus;
  logic [EDW-1:0] err_data;
  logic [EAW-1:0] err_addr;

  always #2 clk = ~clk;

  mbist_seq #(
    .AW (AW), .BASE_ADDR (BASE), .BUS_WORDS (BW), .DATA_WORDS (DW),
    .ADDR_ITERS (AI), .DATA_RANDOM (1'b1), .ADDR_RANDOM (1'b0)
  ) u_mbist_seq (
    .clk (clk), .rst_n (rst_n), .start (start),
    .mem_req_valid (mem_req_valid), .mem_req_ready (mem_req_ready),
    .mem_req_write (mem_req_write), .mem_req_addr (mem_req_addr),
    .mem_req_wdata (mem_req_wdata), .mem_rdata (mem_rdata),
    .done (done), .pass_ok (pass_ok),
    .err_bus (err_bus), .err_data (err_data), .err_addr (err_addr)
  );

  int tests = 0;
  int fails = 0;

  // memory model and expected-sequence state
  logic [31:0] mem [int unsigned];
  int          ep, ei, rb, rd, ra, seq_err;
  logic [31:0] es32;
  logic [15:0] es16;
  int          c_nb, c_nd, c_na, c_hi, c_st;
  logic [15:0] lfsr = 16'hACE1;
  logic        prev_stall = 1'b0;
  logic        p_wr;
  logic [AW-1:0] p_addr;
  logic [31:0] p_wdata;

  function automatic int plen(int p);
    if (p < 4) return BW;
    if (p < 6) return DW;
    return AI;
  endfunction

  function automatic logic [31:0] nxt32(logic [31:0] s);
    return 32'd1664525 * s + 32'd1013904223;
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // memory responder, one step per falling edge
  task automatic respond();
    logic        ew;
    logic [AW-1:0] ea;
    logic [31:0] ed;
    logic [31:0] rv;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    mem_req_ready = (c_st == 0) || lfsr[0];
    mem_rdata = '0;
    if (mem_req_valid) begin
      if (prev_stall && ((p_wr != mem_req_write) || (p_addr != mem_req_addr) || (p_wdata != mem_req_wdata)))
        seq_err++;  // R7
      if (ep >= 8) seq_err++;
      else begin
        ew = (ep % 2) == 0;
        ea = BASE + AW'(ei);
        ed = (ep < 2) ? 32'hAAAA_AAAA : 32'h5555_5555;
        if (ep >= 4 && ep < 6) ed = nxt32(es32);          // R3
        if (ep >= 6) begin ea = BASE + AW'(es16 + 16'd1); ed = 32'(ei); end  // R4
        if ((mem_req_write != ew) || (mem_req_addr != ea) || (ew && (mem_req_wdata != ed)))
          seq_err++;  // R2
      end
      if (mem_req_ready) begin
        if (mem_req_write) mem[32'(mem_req_addr)] = mem_req_wdata;
        else begin
          rv = mem.exists(32'(mem_req_addr)) ? mem[32'(mem_req_addr)] : 32'h0;
          if (ep < 4) begin if (rb < c_nb) rv ^= 32'h1; rb++; end
          else if (ep < 6) begin if (rd < c_nd) rv ^= 32'h8000_0000; rd++; end
          else begin
            if (ra < c_na) rv ^= (c_hi != 0) ? 32'h0001_0000 : 32'h1;
            ra++;
          end
          mem_rdata = rv;
        end
        if (ep >= 4 && ep < 6) es32 = nxt32(es32);
        if (ep >= 6) es16 = es16 + 16'd1;
        if (ei == plen(ep) - 1) begin ep++; ei = 0; es32 = '0; es16 = '0; end
        else ei++;
      end
    end
    prev_stall = mem_req_valid && !mem_req_ready;
    p_wr = mem_req_write; p_addr = mem_req_addr; p_wdata = mem_req_wdata;
  endtask

  initial begin
    c_st = 0; ep = 8;
    forever begin
      @(negedge clk);
      respond();
    end
  end

  task automatic run_case(input int nb, input int nd, input int na, input int hi, input int st, input int inj);
    int eb, edc, eac, cyc;
    c_nb = nb; c_nd = nd; c_na = na; c_hi = hi; c_st = st;
    ep = 0; ei = 0; rb = 0; rd = 0; ra = 0; seq_err = 0; es32 = '0; es16 = '0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(!done && err_bus == 0 && err_data == 0 && err_addr == 0, "R9 clear on start", done, 0);
    cyc = 0;
    while (!done && cyc < 5000) begin
      @(negedge clk);
      cyc++;
      if (inj != 0 && cyc == 25) start = 1'b1;   // R8 mid-run start
      else start = 1'b0;
    end
    start = 1'b0;
    check(done, "R6 done reached", done, 1);
    check(seq_err == 0, "R2/R3/R4/R7/R8 request sequence", seq_err, 0);
    eb  = (nb > 2*BW) ? 2*BW : nb;
    edc = (nd > DW) ? DW : nd;
    eac = (hi != 0) ? 0 : ((na > AI) ? AI : na);
    check(int'(err_bus) == eb, "R2 R5 bus count", err_bus, eb);
    check(int'(err_data) == edc, "R3 R5 data count", err_data, edc);
    check(int'(err_addr) == eac, "R4 R5 addr count", err_addr, eac);
    check(pass_ok == (eb + edc + eac == 0), "R6 pass flag", pass_ok, eb + edc + eac == 0);
    @(negedge clk);
    check(done && !mem_req_valid, "R6 done holds, port quiet", mem_req_valid, 0);
  endtask

  initial begin : watchdog
    #800000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    check(!mem_req_valid && !done && !pass_ok, "R1 reset outputs", mem_req_valid, 0);
    check(err_bus == 0 && err_data == 0 && err_addr == 0, "R1 reset counters", err_bus, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!mem_req_valid && !done, "R1 idle after reset", mem_req_valid, 0);
    for (int v = 0; v < NV; v++)
      run_case(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], VEC[v][5]);
    // R9 restart after a failing run: clean run must report zero
    run_case(0, 0, 0, 0, 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule